// File: doc/BRIEF.md
# Vector Length Set Unit

This unit keeps the current vector length (VL) and the maximum vector length (MAXVL) of a vector-capable core, and updates them when a prefixed instruction carries a nonzero 12-bit length-control field. The field chooses one of four behaviours:
- leave both lengths alone;
- load VL from a small immediate or from a scalar register;
- set MAXVL and VL together from an immediate;
- set MAXVL alone and pull VL down to fit under it.

Every immediate is stored minus one, so a 5-bit code reaches lengths 1 to 32.

When the field names a nonzero destination register, the resulting VL is also sent back to the scalar register file as a one-cycle write request. The scalar register value used by register mode is read by the surrounding pipeline, using the index the unit presents combinationally. A build without vector-length support turns every nonzero field into an illegal-instruction flag.

Top module: `vl_set_unit`

## Requirements
- R1: After reset, VL = 1, MAXVL = 1, and both the write-back request and the illegal flag are low.
- R2: A strobed field of all zeros changes neither VL nor MAXVL and raises neither write-back nor illegal.
- R3: Field layout: bit 11 is the mode bit, bits 10:6 are the destination register, bits 5:1 are the immediate or source register, and bit 0 is the select bit. With mode 0 and select 0, VL becomes immediate + 1, and MAXVL is unchanged.
- R4: With mode 0 and select 1, VL becomes the scalar register value clamped to the range 1..MAXVL, and MAXVL is unchanged. The unit presents bits 5:1 as the source register index at all times.
- R5: With mode 0, select 1 and source index 0, the field is illegal. The illegal flag pulses, and no state changes and no write-back is issued.
- R6: With mode 1 and select 0, both MAXVL and VL become immediate + 1.
- R7: With mode 1 and select 1, MAXVL becomes immediate + 1, and VL becomes the smaller of its old value and the new MAXVL.
- R8: A legal nonzero field with a nonzero destination index requests a write of the new VL, zero-extended, to that register. A destination index of 0 requests no write.
- R9: Results appear on the first clock edge after the strobe. The write-back request and the illegal flag last exactly one cycle unless the strobe repeats.
- R10: When built without length support, any nonzero field raises illegal and leaves VL and MAXVL at 1. An all-zero field is still accepted silently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: a length-control field is present this cycle |
| op_vltyp | input | 12 | Length-control field |
| src_idx | output | 5 | Scalar register index for register mode (field bits 5:1) |
| src_val | input | XLEN | Value of the scalar register named by src_idx |
| vl | output | 6 | Current vector length |
| maxvl | output | 6 | Current maximum vector length |
| wb_valid | output | 1 | One-cycle scalar write-back request |
| wb_idx | output | 5 | Write-back destination register |
| wb_data | output | XLEN | Write-back value (new VL) |
| illegal | output | 1 | One-cycle illegal-instruction flag |

## Verification
Every result of this block is registered. VL, MAXVL, the write-back request and the illegal flag are all due on the first rising edge after the strobe cycle, while src_idx follows the field in the same cycle. The bench drives each strobe on a falling edge and checks src_idx before the next rising edge. It samples the registered results on the following falling edge, one edge after capture, and samples once more a cycle later to confirm that the pulses have dropped.

// File: rtl/vl_set_unit.sv
module vl_set_unit #(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 5,
  parameter int IDX_W  = 5,
  parameter bit HAS_VL = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_valid,
  input  logic [IDX_W+IMM_W+1:0]        op_vltyp,
  output logic [IMM_W-1:0]              src_idx,
  input  logic [XLEN-1:0]               src_val,
  output logic [$clog2((1<<IMM_W)+1)-1:0] vl,
  output logic [$clog2((1<<IMM_W)+1)-1:0] maxvl,
  output logic                          wb_valid,
  output logic [IDX_W-1:0]              wb_idx,
  output logic [XLEN-1:0]               wb_data,
  output logic                          illegal
);
  localparam int TYP_W   = IDX_W + IMM_W + 2;
  localparam int MAX_LEN = 1 << IMM_W;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic             mode_hi, sel;
  logic [IMM_W-1:0] imm;
  logic [IDX_W-1:0] dest;
  logic [LEN_W-1:0] imm_len, reg_len, nxt_vl, nxt_maxvl;
  logic             is_nop, reg_bad, bad_c, apply;

  assign mode_hi = op_vltyp[TYP_W-1];
  assign sel     = op_vltyp[0];
  assign imm     = op_vltyp[IMM_W:1];
  assign dest    = op_vltyp[TYP_W-2 -: IDX_W];
  assign src_idx = imm;
  assign imm_len = LEN_W'(imm) + LEN_W'(1);
  assign is_nop  = (op_vltyp == '0);
  assign reg_bad = !mode_hi && sel && (imm == '0);
  assign bad_c   = !is_nop && (!HAS_VL || reg_bad);
  assign apply   = op_valid && !is_nop && !bad_c;

  always_comb begin
    if (src_val == '0)                  reg_len = LEN_W'(1);
    else if (src_val > XLEN'(maxvl))    reg_len = maxvl;
    else                                reg_len = src_val[LEN_W-1:0];
  end

  always_comb begin
    nxt_vl    = vl;
    nxt_maxvl = maxvl;
    case ({mode_hi, sel})
      2'b00: nxt_vl = imm_len;
      2'b01: nxt_vl = reg_len;
      2'b10: begin nxt_vl = imm_len; nxt_maxvl = imm_len; end
      default: begin
        nxt_maxvl = imm_len;
        nxt_vl    = (vl > imm_len) ? imm_len : vl;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl       <= LEN_W'(1);
      maxvl    <= LEN_W'(1);
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      illegal  <= 1'b0;
    end else begin
      illegal  <= op_valid && bad_c;
      wb_valid <= apply && (dest != '0);
      if (apply) begin
        vl      <= nxt_vl;
        maxvl   <= nxt_maxvl;
        wb_idx  <= dest;
        wb_data <= XLEN'(nxt_vl);
      end
    end
  end

  assert_nop_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_vltyp == '0) |=> ($stable(vl) && $stable(maxvl) && !wb_valid && !illegal));

  assert_reg_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && HAS_VL && !op_vltyp[TYP_W-1] && op_vltyp[0] && op_vltyp[IMM_W:1] != '0)
      |=> (vl >= LEN_W'(1) && vl <= maxvl));

  assert_illegal_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(vl) && $stable(maxvl) && !wb_valid));

  assert_clamp_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && HAS_VL && op_vltyp[TYP_W-1] && op_vltyp[0]) |=> (vl <= maxvl));

  assert_wb_dest_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_idx != '0 && wb_data == XLEN'(vl)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!wb_valid && !illegal));

  assert_no_support_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_VL && op_valid && op_vltyp != '0) |=> illegal);
endmodule

// File: tb/sim_vl_set_unit.sv
module sim_vl_set_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [11:0] op_vltyp = '0;
  logic [63:0] src_val = '0;
  logic [4:0]  src_idx, wb_idx, src_idx1, wb_idx1;
  logic [5:0]  vl, maxvl, vl1, maxvl1;
  logic        wb_valid, illegal, wb_valid1, illegal1;
  logic [63:0] wb_data, wb_data1;
  int n_run = 0, n_fail = 0;
  int m_vl = 1, m_maxvl = 1;

  always #5 clk = ~clk;

  vl_set_unit u0 (.clk, .rst_n, .op_valid, .op_vltyp, .src_idx, .src_val,
    .vl, .maxvl, .wb_valid, .wb_idx, .wb_data, .illegal);

  vl_set_unit #(.HAS_VL(1'b0)) u1 (.clk, .rst_n, .op_valid, .op_vltyp,
    .src_idx(src_idx1), .src_val, .vl(vl1), .maxvl(maxvl1), .wb_valid(wb_valid1),
    .wb_idx(wb_idx1), .wb_data(wb_data1), .illegal(illegal1));

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] fld(input bit mode, input int dst, input int imm, input bit sel);
    return {mode, 5'(dst), 5'(imm), sel};
  endfunction

  // drive one strobe, check results on the next falling edge and the pulse drop after
  task automatic run_op(input string req, input logic [11:0] f, input longint rv,
                        input bit exp_ill);
    int imm = int'(f[5:1]);
    int dst = int'(f[10:6]);
    bit legal = (f != 0) && !exp_ill;
    @(negedge clk);
    op_valid = 1'b1; op_vltyp = f; src_val = 64'(rv);
    #1 chk({req, " src_idx R4"}, src_idx, imm);
    if (legal) begin
      case ({f[11], f[0]})
        2'b00: m_vl = imm + 1;
        2'b01: m_vl = (rv == 0) ? 1 : ((rv > m_maxvl) ? m_maxvl : int'(rv));
        2'b10: begin m_vl = imm + 1; m_maxvl = imm + 1; end
        default: begin m_maxvl = imm + 1; if (m_vl > m_maxvl) m_vl = m_maxvl; end
      endcase
    end
    @(negedge clk);
    op_valid = 1'b0; op_vltyp = '0;
    chk({req, " vl"}, vl, m_vl);
    chk({req, " maxvl"}, maxvl, m_maxvl);
    chk({req, " illegal"}, illegal, exp_ill);
    chk({req, " wb_valid R8"}, wb_valid, legal && dst != 0);
    if (legal && dst != 0) begin
      chk({req, " wb_idx R8"}, wb_idx, dst);
      chk({req, " wb_data R8"}, wb_data, m_vl);
    end
    @(negedge clk);
    chk({req, " wb pulse R9"}, wb_valid, 0);
    chk({req, " illegal pulse R9"}, illegal, 0);
  endtask

  task automatic t_reset;
    chk("R1 vl", vl, 1); chk("R1 maxvl", maxvl, 1);
    chk("R1 wb_valid", wb_valid, 0); chk("R1 illegal", illegal, 0);
  endtask

  task automatic t_nop;       run_op("R2 nop", 12'h000, 64'd77, 1'b0); endtask
  task automatic t_loop_imm;
    run_op("R3 imm code0", fld(0, 3, 0, 0), 0, 1'b0);
    run_op("R3 imm code31", fld(0, 9, 31, 0), 0, 1'b0);
    run_op("R8 dest zero", fld(0, 0, 4, 0), 0, 1'b0);
  endtask
  task automatic t_oneoff;    run_op("R6 oneoff", fld(1, 5, 15, 0), 0, 1'b0); endtask
  task automatic t_loop_reg;
    run_op("R4 reg 10", fld(0, 2, 7, 1), 10, 1'b0);
    run_op("R4 reg big", fld(0, 2, 7, 1), 100, 1'b0);
    run_op("R4 reg zero", fld(0, 2, 7, 1), 0, 1'b0);
    run_op("R4 reg max", fld(0, 1, 7, 1), 16, 1'b0);
  endtask
  task automatic t_bad_reg;   run_op("R5 reg x0", fld(0, 4, 0, 1), 5, 1'b1); endtask
  task automatic t_maxvl_only;
    run_op("R7 shrink", fld(1, 6, 7, 1), 0, 1'b0);
    run_op("R7 grow", fld(1, 6, 20, 1), 0, 1'b0);
  endtask
  task automatic t_back_to_back;
    @(negedge clk);
    op_valid = 1'b1; op_vltyp = fld(0, 3, 2, 0);
    @(negedge clk);
    op_vltyp = fld(0, 3, 4, 0);
    chk("R9 first vl", vl, 3);
    @(negedge clk);
    op_valid = 1'b0; op_vltyp = '0;
    chk("R9 second vl", vl, 5); chk("R9 second wb", wb_valid, 1);
    m_vl = 5;
    @(negedge clk);
    chk("R9 drop", wb_valid, 0);
  endtask
  task automatic t_no_support;
    @(negedge clk);
    op_valid = 1'b1; op_vltyp = fld(1, 5, 9, 0);
    @(negedge clk);
    op_valid = 1'b0; op_vltyp = '0;
    chk("R10 illegal", illegal1, 1); chk("R10 vl", vl1, 1);
    chk("R10 maxvl", maxvl1, 1); chk("R10 wb", wb_valid1, 0);
    @(negedge clk);
    op_valid = 1'b1; op_vltyp = '0;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R10 zero ok", illegal1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nop();
    t_loop_imm();
    t_oneoff();
    t_loop_reg();
    t_bad_reg();
    t_maxvl_only();
    t_back_to_back();
    t_no_support();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule